// File: doc/BRIEF.md
# Framebuffer Window Fetch Address Generator

This block walks a rectangular window that sits inside a wider virtual framebuffer and turns it into a stream of fixed-size read bursts on a plain request/acknowledge memory port. Software supplies a byte start address, the number of bytes to jump over at the end of every visible line, the visible line length and the whole frame size in 32-bit words, a burst size, and a 5-bit pixel offset that tells a downstream unpacker where the first pixel sits inside the first word.

While enabled, the engine offers one burst at a time and moves on when the burst is acknowledged. A burst never runs past the end of a visible line or past the end of the frame. When a line is finished the address jumps by the skip. When the frame is finished the engine starts again at the start address. New settings are taken from the configuration inputs only when an update has been requested, and only at a frame boundary. This lets software pan the window without tearing a frame.

Top module: `fb_window_fetch`

## Requirements
- R1: After reset, mem_req, busy and update_pending are 0, and mem_addr is 0.
- R2: The first burst of every frame is offered at the active start address with its two low bits forced to 0. Every offered address is a multiple of 4.
- R3: Within a visible line, each burst starts 4 times the previous burst's word count above the previous burst's address.
- R4: mem_len_m1 holds the burst word count minus one. The count is cfg_burst_m1+1, or fewer if fewer words remain in the frame or in the current line.
- R5: After the last word of a visible line, the address of the next burst jumps past the line end by the skip in bytes. Bits 1:0 of the skip are ignored.
- R6: While enable stays 1, the burst after the last word of a frame restarts at the start address with full line and frame counts.
- R7: Configuration input changes have no effect until update_req is pulsed. update_req sets update_pending. At the next frame boundary the inputs are loaded and update_pending clears. A frame already in progress completes with the old settings.
- R8: While mem_req is 1 and mem_ack is 0, mem_addr and mem_len_m1 stay unchanged and mem_req stays 1.
- R9: When enable is 0 and the offered burst is acknowledged, mem_req and busy drop on the next cycle. A later enable starts a new frame at the start address.
- R10: pix_off shows the active pixel offset and changes only at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; when low, the engine stops after the offered burst |
| update_req | input | 1 | Pulse that marks the configuration inputs for loading |
| cfg_base | input | AW | Window start byte address |
| cfg_skip | input | SW | Bytes skipped after each visible line (bits 1:0 ignored) |
| cfg_pix_off | input | 5 | Bit offset of the first pixel within the first word |
| cfg_line_words | input | LW | Visible words per line |
| cfg_frame_words | input | FW | Words per frame |
| cfg_burst_m1 | input | BW | Burst size in words minus one |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Burst start byte address |
| mem_len_m1 | output | BW | Burst word count minus one |
| mem_ack | input | 1 | Burst accepted |
| busy | output | 1 | Engine is fetching a frame |
| update_pending | output | 1 | Settings await the next frame boundary |
| pix_off | output | 5 | Active pixel offset |

## Verification
On every cycle the assertions check the following:
- Addresses are word-aligned.
- Burst sizes never exceed the programmed size.
- A waiting request holds still.
- Addresses are contiguous within a line.
- A disable stops the engine after the acknowledged burst.
- Pending updates and the pixel offset move only at frame boundaries.

Some behaviour only the bench's scenarios can show, because it needs an independent walk of the window geometry. This covers the exact address sequence across line skips, and the shortened bursts at line and frame ends. It also covers the return to the start address on every frame, and the deferral of a mid-frame update to the frame after the current one.

// File: rtl/fb_window_fetch.sv
module fb_window_fetch #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int LW = 12,
  parameter int FW = 20,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          update_req,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_skip,
  input  logic [4:0]    cfg_pix_off,
  input  logic [LW-1:0] cfg_line_words,
  input  logic [FW-1:0] cfg_frame_words,
  input  logic [BW-1:0] cfg_burst_m1,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_len_m1,
  input  logic          mem_ack,
  output logic          busy,
  output logic          update_pending,
  output logic [4:0]    pix_off
);

  logic          run, upd_pend;
  logic [AW-1:0] addr, a_base;
  logic [SW-1:0] a_skip;
  logic [4:0]    a_pix;
  logic [LW-1:0] a_line, line_left;
  logic [FW-1:0] a_frame, frame_left;
  logic [BW-1:0] a_bm1;

  logic [FW-1:0] blen, cap_f, n_words;
  logic          xfer, last_line, last_frame, boundary, nx_go;
  logic [AW-1:0] nx_base, step, skip_al;
  logic [LW-1:0] nx_line;
  logic [FW-1:0] nx_frame;

  assign blen       = FW'(a_bm1) + FW'(1);
  assign cap_f      = (frame_left < blen) ? frame_left : blen;
  assign n_words    = (FW'(line_left) < cap_f) ? FW'(line_left) : cap_f;
  assign xfer       = run & mem_ack;
  assign last_line  = (FW'(line_left) == n_words);
  assign last_frame = (frame_left == n_words);
  assign boundary   = (!run && enable) || (xfer && last_frame);

  assign nx_base  = upd_pend ? {cfg_base[AW-1:2], 2'b00} : a_base;
  assign nx_line  = upd_pend ? cfg_line_words : a_line;
  assign nx_frame = upd_pend ? cfg_frame_words : a_frame;
  assign nx_go    = enable && (nx_frame != '0) && (nx_line != '0);

  assign step    = AW'({n_words, 2'b00});
  assign skip_al = AW'({a_skip[SW-1:2], 2'b00});

  assign mem_req        = run;
  assign busy           = run;
  assign mem_addr       = addr;
  assign mem_len_m1     = BW'(n_words - FW'(1));
  assign update_pending = upd_pend;
  assign pix_off        = a_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      upd_pend   <= 1'b0;
      addr       <= '0;
      a_base     <= '0;
      a_skip     <= '0;
      a_pix      <= '0;
      a_line     <= '0;
      a_frame    <= '0;
      a_bm1      <= '0;
      line_left  <= '0;
      frame_left <= '0;
    end else begin
      if (update_req) upd_pend <= 1'b1;
      if (boundary) begin
        if (upd_pend) begin
          a_base  <= nx_base;
          a_skip  <= cfg_skip;
          a_pix   <= cfg_pix_off;
          a_line  <= cfg_line_words;
          a_frame <= cfg_frame_words;
          a_bm1   <= cfg_burst_m1;
          if (!update_req) upd_pend <= 1'b0;
        end
        run        <= nx_go;
        addr       <= nx_base;
        line_left  <= nx_line;
        frame_left <= nx_frame;
      end else if (xfer) begin
        frame_left <= frame_left - n_words;
        if (last_line) begin
          line_left <= a_line;
          addr      <= addr + step + skip_al;
        end else begin
          line_left <= line_left - LW'(n_words);
          addr      <= addr + step;
        end
        if (!enable) run <= 1'b0;
      end
    end
  end

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_len_m1 <= a_bm1);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len_m1));

  p_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && enable && !last_line && !last_frame
    |=> mem_req && mem_addr == $past(mem_addr) + AW'({$past(mem_len_m1), 2'b00}) + AW'(4));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !enable |=> !mem_req && !busy);

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    update_pending && !boundary |=> update_pending);

  p_pix_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(pix_off));

endmodule

// File: tb/fb_window_fetch_test.sv
`timescale 1ns/1ps
module fb_window_fetch_test;
  localparam int AW = 32, SW = 16, LW = 12, FW = 20, BW = 4;
  localparam int NV = 4;
  localparam logic [AW-1:0] T_BASE [NV] = '{32'h0000_1000, 32'h0000_2003, 32'h0000_3000, 32'h0000_4000};
  localparam logic [SW-1:0] T_SKIP [NV] = '{16'h0000, 16'h0040, 16'h0013, 16'h0008};
  localparam logic [LW-1:0] T_LINE [NV] = '{12'd8, 12'd10, 12'd6, 12'd3};
  localparam logic [FW-1:0] T_FRM  [NV] = '{20'd32, 20'd30, 20'd15, 20'd9};
  localparam logic [BW-1:0] T_BM1  [NV] = '{4'd7, 4'd3, 4'd7, 4'd0};
  localparam logic [4:0]    T_PIX  [NV] = '{5'd0, 5'd8, 5'd17, 5'd31};

  logic clk = 0, rst_n = 0, enable = 0, update_req = 0, mem_ack = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_skip = '0;
  logic [4:0]    cfg_pix_off = '0;
  logic [LW-1:0] cfg_line_words = '0;
  logic [FW-1:0] cfg_frame_words = '0;
  logic [BW-1:0] cfg_burst_m1 = '0;
  logic mem_req, busy, update_pending;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_len_m1;
  logic [4:0] pix_off;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fb_window_fetch #(.AW(AW), .SW(SW), .LW(LW), .FW(FW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .update_req(update_req),
    .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_pix_off(cfg_pix_off),
    .cfg_line_words(cfg_line_words), .cfg_frame_words(cfg_frame_words),
    .cfg_burst_m1(cfg_burst_m1), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len_m1(mem_len_m1), .mem_ack(mem_ack), .busy(busy),
    .update_pending(update_pending), .pix_off(pix_off));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic program_cfg(input logic [AW-1:0] b, input logic [SW-1:0] s, input logic [LW-1:0] l,
                             input logic [FW-1:0] f, input logic [BW-1:0] m, input logic [4:0] p);
    cfg_base = b; cfg_skip = s; cfg_line_words = l; cfg_frame_words = f; cfg_burst_m1 = m; cfg_pix_off = p;
  endtask

  // one handshake: inspect offered burst, acknowledge it
  task automatic serve(input longint ea, input int el, input int ep, input string tag);
    @(negedge clk);
    chk(mem_req === 1'b1, {tag, " req"}, mem_req, 1);
    chk(mem_addr === ea[AW-1:0], {tag, " addr"}, mem_addr, ea);
    chk(mem_len_m1 === el[BW-1:0], {tag, " len"}, mem_len_m1, el);
    chk(pix_off === ep[4:0], "R10 pix_off", pix_off, ep);
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    update_req = 0;
  endtask

  // independent model of one frame walk (R2 R3 R4 R5)
  task automatic run_frame(input longint base, input longint skip, input int line, input int frame,
                           input int bm1, input int pix, input bit upd_mid);
    longint a = base & ~64'h3;
    int fl = frame, ll = line, n, k = 0;
    while (fl > 0) begin
      n = bm1 + 1;
      if (fl < n) n = fl;
      if (ll < n) n = ll;
      if (upd_mid && k == 0) update_req = 1;
      serve(a, n - 1, pix, (k == 0) ? "R2 frame start" : "R3/R4/R5 walk");
      if (upd_mid && k == 0)
        chk(update_pending === 1'b1, "R7 pending mid-frame", update_pending, 1);
      a += 4 * n; fl -= n; ll -= n;
      if (ll == 0) begin a += skip & ~64'h3; ll = line; end
      k++;
    end
  endtask

  task automatic pulse_update();
    @(negedge clk); update_req = 1;
    @(negedge clk); update_req = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req === 1'b0, "R1 req", mem_req, 0);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(update_pending === 1'b0, "R1 pending", update_pending, 0);
    chk(mem_addr === '0, "R1 addr", mem_addr, 0);

    for (int i = 0; i < NV; i++) begin
      program_cfg(T_BASE[i], T_SKIP[i], T_LINE[i], T_FRM[i], T_BM1[i], T_PIX[i]);
      pulse_update();
      chk(update_pending === 1'b1, "R7 pending set", update_pending, 1);
      enable = 1;
      run_frame(T_BASE[i], T_SKIP[i], T_LINE[i], T_FRM[i], T_BM1[i], T_PIX[i], 0);
      chk(update_pending === 1'b0, "R7 pending cleared", update_pending, 0);
      run_frame(T_BASE[i], T_SKIP[i], T_LINE[i], T_FRM[i], T_BM1[i], T_PIX[i], 0); // R6 restart
      enable = 0;
      serve(T_BASE[i] & ~32'h3, ((T_BM1[i] < T_LINE[i]) ? T_BM1[i] + 1 : T_LINE[i]) - 1, T_PIX[i], "R9 last burst");
      chk(mem_req === 1'b0, "R9 req dropped", mem_req, 0);
      chk(busy === 1'b0, "R9 busy dropped", busy, 0);
    end

    // R7/R10: changes without update ignored, mid-frame update deferred
    program_cfg(32'h0000_1000, 16'h0, 12'd8, 20'd32, 4'd7, 5'd5);
    pulse_update();
    enable = 1;
    serve(32'h1000, 7, 5, "R7 frame A start");
    program_cfg(32'h0000_8000, 16'h0, 12'd4, 20'd8, 4'd3, 5'd9);
    serve(32'h1020, 7, 5, "R7 unchanged walk");
    serve(32'h1040, 7, 5, "R7 unchanged walk");
    serve(32'h1060, 7, 5, "R7 unchanged walk");
    chk(update_pending === 1'b0, "R7 no pending without update", update_pending, 0);
    run_frame(32'h1000, 0, 8, 32, 7, 5, 1);
    chk(update_pending === 1'b0, "R7 pending cleared at boundary", update_pending, 0);
    run_frame(32'h8000, 0, 4, 8, 3, 9, 0);
    enable = 0;
    serve(32'h8000, 3, 9, "R9 stop burst");
    chk(busy === 1'b0, "R9 idle", busy, 0);
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0, "R9 stays idle", mem_req, 0);
    enable = 1;
    serve(32'h8000, 3, 9, "R9 re-enable at base");
    enable = 0;
    serve(32'h8010, 3, 9, "R3 final burst");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule